// File: doc/BRIEF.md
# Bus Read Turnaround Delay Inserter

This block sits between the request stream of an external bus controller and its bus sequencer. After a read from a slow external device it holds back the next bus operation for a programmed number of idle cycles, so that the device has released the shared data lines before anyone else drives them. Each request carries an area index, a write flag and a flag that marks an on-chip target. The block accepts a request when `req_valid` and `req_ready` are both high.

Every external area has its own 2-bit turnaround setting. The block records the last accepted access and starts a down-counter from that area's setting whenever an external read is accepted. While the counter is nonzero, a following request is held only if the pair of accesses actually risks contention. Such a pair is a write, a read to a different area, or a read to an on-chip target. Idle time between requests counts toward the gap, so a late request is delayed less or not at all.

Top module: `rd_turnaround_gate`

## Requirements
- R1: After reset the access record is empty and the counter is zero, so the first request is granted in the cycle it is presented.
- R2: A write that follows an external read from area A is held for exactly D(A) cycles. D(A) is the field `cfg_dly[2A+1:2A]`, from 0 to 3.
- R3: A read to a different external area that follows an external read from area A is held for exactly D(A) cycles.
- R4: A read with `req_internal`=1 that follows an external read from area A is held for exactly D(A) cycles.
- R5: A request that follows an accepted write is never held.
- R6: A read to the same external area as the previous external read is never held.
- R7: When D(A) is 0, a following write or different-area read is granted in the cycle it is presented.
- R8: Cycles with no request count toward the gap. A request presented k cycles after the read was accepted is held for max(0, D(A)+1-k) cycles, and a request is never held for more than 3 cycles in a row.
- R9: `turn_idle` is high in exactly those cycles in which a presented request is held.
- R10: A request that follows an accepted read with `req_internal`=1 is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dly | input | N_AREAS*DLY_W | Turnaround setting per area, area k at bits [DLY_W*k +: DLY_W] |
| req_valid | input | 1 | A request is presented |
| req_area | input | AW | Area index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | Request targets an on-chip device |
| req_ready | output | 1 | Grant to the bus sequencer; low means hold |
| turn_idle | output | 1 | A presented request is being held for turnaround |

## Verification
Two things can land on the same clock edge: the acceptance of a new external read, which reloads the counter, and the ongoing countdown of the previous gap. A same-area read has to pass through while the counter is still nonzero, and the reload must then restart the gap from the new area's setting. The bench provokes this with same-area reads issued back to back, with reads into areas whose settings differ, and with random idle spacing. Every cycle it compares grant and idle against a model that keeps only the acceptance cycle number and the setting of the last read.

// File: rtl/rd_turnaround_gate.sv
module rd_turnaround_gate #(
  parameter int N_AREAS = 8,
  parameter int DLY_W   = 2,
  localparam int AW     = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_AREAS*DLY_W-1:0] cfg_dly,
  input  logic                     req_valid,
  input  logic [AW-1:0]            req_area,
  input  logic                     req_write,
  input  logic                     req_internal,
  output logic                     req_ready,
  output logic                     turn_idle
);

  logic [DLY_W-1:0] cnt;
  logic             prev_vld;
  logic             prev_wr;
  logic             prev_int;
  logic [AW-1:0]    prev_area;

  logic [DLY_W-1:0] sel_dly;
  logic             accept;
  logic             differ;
  logic             hold;
  logic             ext_rd;

  assign sel_dly   = cfg_dly[req_area*DLY_W +: DLY_W];
  assign ext_rd    = ~req_write & ~req_internal;
  assign differ    = req_write | req_internal | (req_area != prev_area);
  assign hold      = prev_vld & ~prev_wr & ~prev_int & (cnt != '0) & differ;
  assign req_ready = ~hold;
  assign turn_idle = req_valid & hold;
  assign accept    = req_valid & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev_vld  <= 1'b0;
      prev_wr   <= 1'b0;
      prev_int  <= 1'b0;
      prev_area <= '0;
    end else if (accept) begin
      prev_vld  <= 1'b1;
      prev_wr   <= req_write;
      prev_int  <= req_internal;
      prev_area <= req_area;
      cnt       <= ext_rd ? sel_dly : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rd_turnaround_gate_chk.sv
module rd_turnaround_gate_chk #(
  parameter int N_AREAS = 8,
  parameter int DLY_W   = 2,
  localparam int AW     = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_AREAS*DLY_W-1:0] cfg_dly,
  input logic                     req_valid,
  input logic [AW-1:0]            req_area,
  input logic                     req_write,
  input logic                     req_internal,
  input logic                     req_ready,
  input logic                     turn_idle
);

  localparam int MAX_RUN = (1 << DLY_W) - 1;

  logic       acc;
  logic       started;
  logic [7:0] run;

  assign acc = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      run     <= turn_idle ? ((run == 8'hff) ? run : run + 1'b1) : '0;
    end
  end

  a_r1_first_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> req_ready);

  a_r5_no_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc && req_write) |-> req_ready);

  a_r6_same_area_pass: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc && !req_write && !req_internal) && req_valid &&
    !req_write && !req_internal && req_area == $past(req_area) |-> req_ready);

  a_r7_zero_setting: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc && !req_write && !req_internal &&
    cfg_dly[req_area*DLY_W +: DLY_W] == '0) |-> req_ready);

  a_r8_bounded_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 8'(MAX_RUN));

  a_r10_internal_read_free: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc && !req_write && req_internal) |-> req_ready);

endmodule

bind rd_turnaround_gate rd_turnaround_gate_chk #(.N_AREAS(N_AREAS), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/rd_turnaround_gate_tb.sv
module rd_turnaround_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_AREAS = 8;
  localparam int DLY_W = 2;
  localparam int AW = 3;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [N_AREAS*DLY_W-1:0] cfg_dly;
  logic                     req_valid = 1'b0;
  logic [AW-1:0]            req_area = '0;
  logic                     req_write = 1'b0;
  logic                     req_internal = 1'b0;
  logic                     req_ready;
  logic                     turn_idle;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int m_have_rd = 0;
  int m_area = 0;
  int m_dly = 0;
  int m_acc_cyc = 0;

  rd_turnaround_gate #(.N_AREAS(N_AREAS), .DLY_W(DLY_W)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dly_of(int a);
    return int'(cfg_dly[a*DLY_W +: DLY_W]);
  endfunction

  function automatic bit model_ready();
    bit risky;
    if (!req_valid || !m_have_rd) return 1'b1;
    risky = req_write || req_internal || (int'(req_area) != m_area);
    return !(risky && (cyc - m_acc_cyc) <= m_dly);
  endfunction

  task automatic check(string tag, bit exp_rdy);
    bit exp_idle;
    exp_idle = req_valid && !exp_rdy;
    n_cmp++;
    if (req_ready !== exp_rdy || turn_idle !== exp_idle) begin
      n_bad++;
      $display("FAIL %s cyc=%0d ready/idle actual=%b%b expected=%b%b",
               tag, cyc, req_ready, turn_idle, exp_rdy, exp_idle);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1 check("R9", 1'b1);
    end
  endtask

  task automatic issue(string tag, int area, bit wr, bit intl, int exp_stall);
    bit done;
    int stalls;
    done = 1'b0;
    stalls = 0;
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_area = AW'(area);
      req_write = wr;
      req_internal = intl;
      #1;
      check(tag, model_ready());
      if (model_ready()) begin
        done = 1'b1;
        m_have_rd = (!wr && !intl);
        m_area = area;
        m_dly = dly_of(area);
        m_acc_cyc = cyc;
      end else begin
        stalls++;
      end
      if (stalls > 10) done = 1'b1;
    end
    if (exp_stall >= 0) begin
      n_cmp++;
      if (stalls != exp_stall) begin
        n_bad++;
        $display("FAIL %s stall count actual=%0d expected=%0d", tag, stalls, exp_stall);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1 check(tag, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cfg_dly = {2'd2, 2'd3, 2'd3, 2'd1, 2'd3, 2'd2, 2'd1, 2'd0};
    #(CLK_PERIOD * 3);
    @(negedge clk);
    #1 check("R1", 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_area = 3'd4; req_write = 1'b1;
    #1 check("R1", 1'b1);
    req_valid = 1'b0; req_write = 1'b0;

    // issue() returns one cycle after acceptance (k=2), so every direct follow-up stalls D-1
    issue("R1", 3, 0, 0, 0);
    issue("R2", 3, 1, 0, -1);
    issue("R2", 3, 0, 0, 0);
    @(negedge clk); req_valid = 1'b1; req_area = 3'd1; req_write = 1'b1;
    #1 check("R2", 1'b0);
    idle(0);
    issue("R2", 1, 1, 0, 1);
    issue("R5", 2, 0, 0, 0);
    issue("R6", 2, 0, 0, 0);
    issue("R6", 2, 0, 0, 0);
    issue("R3", 5, 0, 0, 1);
    issue("R4", 0, 0, 1, 2);
    issue("R10", 1, 0, 0, 0);
    issue("R3", 0, 0, 0, 0);
    issue("R7", 4, 1, 0, 0);
    issue("R6", 6, 0, 0, 0);
    issue("R3", 6, 0, 0, 0);
    issue("R8", 6, 1, 0, 2);
    issue("R8", 3, 0, 0, 0);
    idle(2);
    issue("R8", 5, 0, 0, 0);
    idle(4);
    issue("R8", 1, 1, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int a;
      a = $urandom_range(0, N_AREAS - 1);
      if ((i % 50) == 0) cfg_dly = N_AREAS*DLY_W'($urandom);
      issue("R8", a, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0), -1);
      idle($urandom_range(0, 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule